// File: doc/BRIEF.md
# Two-Beat Sequenced Arithmetic and Shift Unit

This unit computes one 8-bit result at a time from operands delivered over a single shared input bus. Each operation starts with a beat that carries a 4-bit opcode and the first operand, A. Add and subtract take a second beat that carries operand B. Shift operations take only the first beat and then move A through a barrel shifter. Add and subtract use a carry-lookahead adder that works in grouped stages. The result lands in an output register. It is also written into a small ring of result slots.

Any operation can take its A operand from the most recent result instead of from the bus. This lets a host chain operations without sending data back. The input side uses valid/ready handshaking. A beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_data` and `in_op` steady until that edge. `in_ready` is low for the one execute cycle of each operation, and any beat offered then waits. The output side has no back-pressure. `out_valid` is a single-cycle strobe, and `out_data` and `out_carry` hold their value until the next result, so a consumer can also read them later.

Top module: `seq_alu`

## Requirements
- R1: After reset, `out_valid`, `out_data` and `out_carry` are 0, and `in_ready` is 1.
- R2: Opcode bits [2:0] = 000 is an add. The second accepted beat supplies B. `out_data` = (A+B) mod 256 and `out_carry` is bit 8 of the sum. The result appears one clock after the second beat is accepted.
- R3: Opcode bits [2:0] = 001 is a subtract, computed as A + ~B + 1 mod 256. `out_carry` is 1 exactly when A >= B.
- R4: Codes 010, 011 and 100 shift A left by 1, 2 and 3 bits. Vacated bits are filled with zeros, and `out_carry` is 0.
- R5: Codes 101, 110 and 111 shift A right logically by 1, 2 and 3 bits. Vacated bits are filled with zeros, and `out_carry` is 0.
- R6: A shift uses a single input beat. Its result appears one clock after that beat is accepted.
- R7: When opcode bit 3 is 1, A is the most recently produced result, and the bus value on the first beat is ignored.
- R8: Results go into a four-slot ring with a wrapping write pointer. Before any result has been produced, a memory-sourced A reads 0.
- R9: `out_valid` is high for exactly the one cycle after the result register loads. `out_data` and `out_carry` keep their value until the next result.
- R10: `in_ready` is high while idle and while waiting for B. It is low during the execute cycle, and a beat offered then is ignored. The opcode lines on the B beat are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Unit can take a beat |
| in_data | input | 8 | Operand A on the first beat, B on the second |
| in_op | input | 4 | Opcode, sampled on the first beat only |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 8 | Held result value |
| out_carry | output | 1 | Carry out of the add/subtract, 0 for shifts |

## Verification
Every result is due exactly one rising edge after the last accepted beat. For add and subtract that is the B beat, and for shifts it is the single beat. The bench drives on falling edges and samples on the falling edge that follows the result edge. There it expects `out_valid` high and the value worked out arithmetically from the operands. One falling edge later it checks that the strobe has dropped and the value is unchanged. During the execute cycle the bench checks that `in_ready` is low and sometimes offers a decoy beat. It then confirms the decoy had no effect, using a memory-sourced operation that reads the previous result back.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_SL1 = 3'd2,
    FN_SL2 = 3'd3,
    FN_SL3 = 3'd4,
    FN_SR1 = 3'd5,
    FN_SR2 = 3'd6,
    FN_SR3 = 3'd7
  } alu_fn_e;

  typedef struct packed {
    logic    use_mem;
    alu_fn_e fn;
  } opcode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_B,
    ST_EXEC_ARITH,
    ST_EXEC_SHIFT
  } seq_state_e;

  function automatic logic fn_is_shift(alu_fn_e f);
    return (f != FN_ADD) && (f != FN_SUB);
  endfunction

  function automatic logic fn_is_left(alu_fn_e f);
    return (f == FN_SL1) || (f == FN_SL2) || (f == FN_SL3);
  endfunction

  function automatic logic [1:0] fn_shift_amt(alu_fn_e f);
    case (f)
      FN_SL1, FN_SR1: return 2'd1;
      FN_SL2, FN_SR2: return 2'd2;
      FN_SL3, FN_SR3: return 2'd3;
      default:        return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/alu_seq_ctrl.sv
module alu_seq_ctrl
  import seq_alu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  opcode_t op_in,
  output logic    in_ready,
  output logic    load_a,
  output logic    load_b,
  output logic    fire_arith,
  output logic    fire_shift,
  output opcode_t op_q
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    in_ready   = 1'b0;
    load_a     = 1'b0;
    load_b     = 1'b0;
    fire_arith = 1'b0;
    fire_shift = 1'b0;
    case (state_q)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          load_a  = 1'b1;
          state_d = fn_is_shift(op_in.fn) ? ST_EXEC_SHIFT : ST_WAIT_B;
        end
      end
      ST_WAIT_B: begin
        in_ready = 1'b1;
        if (in_valid) begin
          load_b  = 1'b1;
          state_d = ST_EXEC_ARITH;
        end
      end
      ST_EXEC_ARITH: begin
        fire_arith = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_EXEC_SHIFT: begin
        fire_shift = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (load_a) op_q <= op_in;
    end
  end

  // R6: a single accepted shift beat leads straight to the shift execute cycle
  p_one_beat_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a && fn_is_shift(op_in.fn)) |=> (fire_shift && !in_ready));

  // R2: an accepted B beat is followed by the arithmetic execute cycle
  p_b_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |=> (fire_arith && !in_ready));

  // R10: an execute cycle always returns to idle with ready high
  p_exec_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_arith || fire_shift) |=> in_ready);

endmodule

// File: rtl/cla_addsub.sv
module cla_addsub #(
  parameter int W   = 8,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int NG = W / GRP;

  logic [W-1:0]  bx, g, p;
  logic [NG-1:0] ggen, gprop;
  logic [NG:0]   cg;

  assign bx = sub ? ~b : b;
  assign g  = a & bx;
  assign p  = a ^ bx;

  // group generate / propagate, independent of carry-in
  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    localparam int BASE = gi * GRP;
    logic [GRP-1:0] cl;

    always_comb begin : grp_gp
      logic acc;
      acc = 1'b0;
      for (int k = 0; k < GRP; k++) acc = g[BASE+k] | (p[BASE+k] & acc);
      ggen[gi]  = acc;
      gprop[gi] = &p[BASE +: GRP];
    end

    // carries inside the group, each looked ahead from the group carry-in
    always_comb begin : grp_carry
      logic t;
      cl = '0;
      for (int i = 0; i < GRP; i++) begin
        t = cg[gi];
        for (int k = 0; k < i; k++) t = g[BASE+k] | (p[BASE+k] & t);
        cl[i] = t;
      end
    end

    assign sum[BASE +: GRP] = p[BASE +: GRP] ^ cl;
  end

  always_comb begin
    cg[0] = sub;
    for (int j = 0; j < NG; j++) cg[j+1] = ggen[j] | (gprop[j] & cg[j]);
  end

  assign cout = cg[NG];

  always_comb begin
    if (!sub)
      p_add_sum_r2: assert ({cout, sum} == ({1'b0, a} + {1'b0, b}))
        else $error("adder sum mismatch");
    else
      p_sub_borrow_r3: assert (cout == (a >= b))
        else $error("subtract carry mismatch");
  end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic [W-1:0]  din,
  input  logic          left,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);

  always_comb begin
    logic [W-1:0] v;
    v = din;
    for (int s = 0; s < AW; s++) begin
      if (amt[s]) v = left ? (v << (1 << s)) : (v >> (1 << s));
    end
    dout = v;
  end

  always_comb begin
    if (left && amt != '0)
      p_fill_zero_r4: assert (dout[0] == 1'b0) else $error("left fill not zero");
    if (!left && amt != '0)
      p_fill_zero_r5: assert (dout[W-1] == 1'b0) else $error("right fill not zero");
  end

endmodule

// File: rtl/result_store.sv
module result_store #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latest
);

  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wptr_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                 slot_q[i] <= '0;
      else if (wr_en && wptr_q == PW'(i))         slot_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     wptr_q <= '0;
    else if (wr_en) wptr_q <= wptr_q + 1'b1;
  end

  assign latest = slot_q[wptr_q - 1'b1];

  // R8: pointer advances by one per write, wrapping at the ring size
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wptr_q == $past(wptr_q) + 1'b1));

  // R7: the slot read back after a write holds the written value
  p_latest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (latest == $past(wr_data)));

endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import seq_alu_pkg::*;
#(
  parameter int W         = 8,
  parameter int MEM_DEPTH = 4,
  parameter int CLA_GROUP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic [3:0]   in_op,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_carry
);

  opcode_t      op_in, op_q;
  logic         load_a, load_b, fire_arith, fire_shift, fire;
  logic [W-1:0] reg_a, reg_b, mem_latest, add_sum, shift_out, next_res;
  logic         add_cout, next_carry;

  assign op_in = opcode_t'(in_op);
  assign fire  = fire_arith | fire_shift;

  alu_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_in      (op_in),
    .in_ready   (in_ready),
    .load_a     (load_a),
    .load_b     (load_b),
    .fire_arith (fire_arith),
    .fire_shift (fire_shift),
    .op_q       (op_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (load_a) reg_a <= op_in.use_mem ? mem_latest : in_data;
      if (load_b) reg_b <= in_data;
    end
  end

  cla_addsub #(.W(W), .GRP(CLA_GROUP)) u_add (
    .a    (reg_a),
    .b    (reg_b),
    .sub  (op_q.fn == FN_SUB),
    .sum  (add_sum),
    .cout (add_cout)
  );

  barrel_shifter #(.W(W), .AW(2)) u_shift (
    .din  (reg_a),
    .left (fn_is_left(op_q.fn)),
    .amt  (fn_shift_amt(op_q.fn)),
    .dout (shift_out)
  );

  assign next_res   = fire_arith ? add_sum : shift_out;
  assign next_carry = fire_arith & add_cout;

  result_store #(.W(W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire),
    .wr_data (next_res),
    .latest  (mem_latest)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_carry <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_data  <= next_res;
        out_carry <= next_carry;
      end
    end
  end

  // R9: the strobe never lasts two cycles
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9: the output value moves only together with the strobe
  p_hold_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_carry)));

  // R4: shifts never report a carry
  p_shift_no_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_shift |=> !out_carry);

  // R10: ready is low while the strobe is being prepared
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !in_ready);

endmodule

// File: tb/sim_seq_alu.sv
module sim_seq_alu;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [3:0] in_op = '0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_carry;

  int         n_checks = 0;
  int         n_errors = 0;
  logic [7:0] last_res = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_alu u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_carry (out_carry)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one full operation; result expected one edge after the last beat
  task automatic run_op(input logic [3:0] op, input logic [7:0] a_bus,
                        input logic [7:0] b_bus, input string req, input bit poke_busy);
    logic [2:0] fn;
    logic [7:0] a_eff, sh;
    logic [8:0] exp;
    fn    = op[2:0];
    a_eff = op[3] ? last_res : a_bus;
    case (fn)
      3'd0: exp = {1'b0, a_eff} + {1'b0, b_bus};
      3'd1: exp = {1'b0, a_eff} + {1'b0, ~b_bus} + 9'd1;
      3'd2, 3'd3, 3'd4: begin sh = a_eff << (fn - 3'd1); exp = {1'b0, sh}; end
      default:          begin sh = a_eff >> (fn - 3'd4); exp = {1'b0, sh}; end
    endcase

    @(negedge clk);
    chk(in_ready, "R10 ready when idle", in_ready, 1);
    in_valid = 1'b1; in_op = op; in_data = a_bus;
    @(negedge clk);
    if (fn <= 3'd1) begin
      chk(in_ready, "R10 ready for B", in_ready, 1);
      in_data = b_bus;
      in_op   = 4'hF;        // R10: opcode on the B beat is ignored
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(!in_ready, "R6/R10 busy in execute", in_ready, 0);
    chk(!out_valid, "R9 no early strobe", out_valid, 0);
    if (poke_busy) begin
      in_valid = 1'b1; in_op = 4'b0010; in_data = 8'hFF;   // decoy during execute
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid, {req, " strobe"}, out_valid, 1);
    chk(out_data == exp[7:0], {req, " data"}, out_data, exp[7:0]);
    chk(out_carry == exp[8], {req, " carry"}, out_carry, exp[8]);
    last_res = exp[7:0];
    @(negedge clk);
    chk(!out_valid, "R9 strobe one cycle", out_valid, 0);
    chk(out_data == exp[7:0], "R9 value held", out_data, exp[7:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(out_data == 8'h00, "R1 out_data", out_data, 0);
    chk(!out_carry, "R1 out_carry", out_carry, 0);
    chk(in_ready, "R1 in_ready", in_ready, 1);

    // R8: memory operand before any result reads zero (0 + 0x33)
    run_op(4'b1000, 8'hA5, 8'h33, "R8 empty memory", 1'b0);

    // R2/R3 corners
    run_op(4'b0000, 8'hFF, 8'h01, "R2 wrap", 1'b0);
    run_op(4'b0000, 8'h80, 8'h80, "R2 carry", 1'b0);
    run_op(4'b0001, 8'h00, 8'h01, "R3 borrow", 1'b0);
    run_op(4'b0001, 8'h5A, 8'h5A, "R3 equal", 1'b0);
    run_op(4'b0001, 8'hFF, 8'h00, "R3 max", 1'b0);

    // R2/R3 sweep
    for (int a = 0; a < 256; a += 15)
      for (int b = 0; b < 256; b += 13) begin
        run_op(4'b0000, 8'(a), 8'(b), "R2 add sweep", 1'b0);
        run_op(4'b0001, 8'(a), 8'(b), "R3 sub sweep", 1'b0);
      end

    // R4/R5/R6 exhaustive shift sweep
    for (int a = 0; a < 256; a++)
      for (int f = 2; f < 8; f++)
        run_op({1'b0, 3'(f)}, 8'(a), 8'h00,
               (f < 5) ? "R4 left shift" : "R5 right shift", 1'b0);

    // R7 chained memory operands, with R10 decoys in the execute cycle
    run_op(4'b0000, 8'h17, 8'h29, "R7 seed", 1'b0);
    for (int i = 0; i < 48; i++)
      run_op({1'b1, 3'(i % 8)}, 8'(8'hC3 ^ i), 8'(i * 7 + 3),
             "R7 chained", (i % 3) == 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule